// File: doc/BRIEF.md
# Delegated Counter Indirect Access Unit

This unit serves supervisor-level indirect register accesses whose select value falls inside a 32-entry counter-delegation window. It turns the select offset and the alias register number into a machine counter target: a counter value, its configuration or event selector, or one of their upper halves. It checks whether the current privilege state may reach that target. On configuration targets it also hides the machine-mode inhibit filter bit and keeps that bit unchanged on writes.

The surrounding register file decodes the alias number (1 to 6) from the accessed address. It sets `vs_alias` when the address is the virtual-supervisor copy, which sits 0x100 above the supervisor copy. The unit drives the target index and a write strobe with merged data in the same cycle. The counter storage returns the current target contents on `mrd_data` in that same cycle. One cycle later a registered response carries the read data, the trap kind, or a flag saying the select value was not in this unit's window.

Top module: `cnt_deleg_ind`

## Requirements
- R1: A select value outside [WIN_BASE, WIN_BASE+31] (WIN_BASE defaults to 0x40) is unclaimed. The response has `rsp_not_mine`=1, no trap flag and zero read data, and no write is issued.
- R2: The select offset is `sel - WIN_BASE` and appears in `tgt_idx[4:0]`. Offset 0 is the cycle counter and offset 2 is the retired-instruction counter. Offsets 3 to 2+NUM_HPM are performance counters. Offset 1 and higher offsets are absent.
- R3: Alias 1 reaches the value (`tgt_idx[5]`=0) and alias 2 the configuration/event register (`tgt_idx[5]`=1). Aliases 4 and 5 reach the upper halves of those registers (`tgt_idx[6]`=1), and exist only when XLEN=32. Aliases 0, 3, 6 and 7 are absent for every select.
- R4: Reads through aliases 2 and 5 return the target with the inhibit bit cleared. The inhibit bit is bit INH_POS (default 62) of the full register; for alias 5 it is bit INH_POS-32 of the upper half.
- R5: Writes through aliases 2 and 5 keep the target's current inhibit bit and take every other bit of `mwr_data` from `wdata`. Writes through other aliases pass `wdata` unchanged.
- R6: From M mode (`priv`=3) or non-virtual S mode (`priv`=1, `virt`=0), an access raises an illegal-instruction trap in any of three cases: the target is absent, `deleg_en` is 0, or `cnt_en[offset]` is 0.
- R7: Otherwise, from those modes, an access with `vs_alias`=1 raises an illegal-instruction trap.
- R8: From VS mode (`priv`=1, `virt`=1), any in-window access raises a virtual-instruction trap when `deleg_en`=1, and an illegal-instruction trap when `deleg_en`=0.
- R9: An in-window access from U mode (`priv`=0), or with the reserved `priv`=2, raises an illegal-instruction trap.
- R10: A trapped or unclaimed access issues no write and returns zero read data, and at most one trap flag is ever set.
- R11: `tgt_idx`, `mwr_en` and `mwr_data` are combinational in the access cycle. `mwr_en` is set only for a write that is claimed and not trapped. The `rsp_*` outputs are registered one cycle after `acc_valid` and are all zero during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Indirect access present this cycle |
| acc_write | input | 1 | Access is a write |
| sel | input | SEL_W | Indirect select value |
| alias_idx | input | 3 | Alias register number 1 to 6 |
| vs_alias | input | 1 | Access uses the virtual-supervisor alias copy |
| priv | input | 2 | Privilege: 0 U, 1 S, 3 M |
| virt | input | 1 | Virtualization mode |
| deleg_en | input | 1 | Counter delegation enable |
| cnt_en | input | 32 | Per-counter enable mask |
| wdata | input | XLEN | Write data |
| mrd_data | input | XLEN | Current contents of the target from counter storage |
| tgt_idx | output | 7 | {upper half, config, counter number} |
| mwr_en | output | 1 | Write strobe to counter storage |
| mwr_data | output | XLEN | Merged write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | XLEN | Read data |
| rsp_illegal | output | 1 | Illegal-instruction trap |
| rsp_virtual | output | 1 | Virtual-instruction trap |
| rsp_not_mine | output | 1 | Select outside the delegation window |

## Verification
A successful access is the hardest case to reach from the ports. It needs an in-window select, a present counter and alias, M or non-virtual S mode, delegation enabled, the matching enable bit set and the plain alias, all at once. Uniform random inputs almost never line these up. The stimulus therefore biases the random inputs toward delegation on, a full enable mask and non-virtual high privilege. Directed accesses then take away one condition at a time. Two instances run in parallel, a 64-bit one with all counters and a 32-bit one with four performance counters, so that the upper-half aliases and the absent-counter boundary are both covered.

// File: rtl/cdi_pkg.sv
package cdi_pkg;
   localparam int WIN_SIZE = 32;
   localparam int OFF_W    = $clog2(WIN_SIZE);

   localparam logic [1:0] PRV_U = 2'd0;
   localparam logic [1:0] PRV_S = 2'd1;
   localparam logic [1:0] PRV_M = 2'd3;

   typedef enum logic [2:0] {
      AL_RSV0   = 3'd0,
      AL_VAL    = 3'd1,
      AL_CFG    = 3'd2,
      AL_VOID3  = 3'd3,
      AL_VAL_HI = 3'd4,
      AL_CFG_HI = 3'd5,
      AL_VOID6  = 3'd6,
      AL_RSV7   = 3'd7
   } cdi_alias_e;

   typedef struct packed {
      logic             hi;
      logic             cfg;
      logic [OFF_W-1:0] num;
   } cdi_tgt_t;
endpackage

// File: rtl/cdi_decode.sv
module cdi_decode
   import cdi_pkg::*;
#(
   parameter int          SEL_W    = 12,
   parameter int unsigned WIN_BASE = 'h40,
   parameter int          NUM_HPM  = 29,
   parameter int          XLEN     = 64
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [2:0]       alias_idx,
   output logic             in_win,
   output logic [OFF_W-1:0] off,
   output cdi_tgt_t         tgt,
   output logic             present
);
   localparam logic [SEL_W-1:0] BASE_L  = SEL_W'(WIN_BASE);
   localparam logic [SEL_W-1:0] SIZE_L  = SEL_W'(WIN_SIZE);
   localparam logic [OFF_W:0]   HPM_END = (OFF_W+1)'(3 + NUM_HPM);

   logic [SEL_W-1:0] diff;
   logic             cnt_ok;
   logic             lo_alias;
   logic             hi_alias;
   logic             hi_ok;

   assign diff   = sel - BASE_L;
   assign in_win = (sel >= BASE_L) && (diff < SIZE_L);
   assign off    = diff[OFF_W-1:0];

   always_comb begin
      cnt_ok = 1'b0;
      if (off == OFF_W'(0) || off == OFF_W'(2))
         cnt_ok = 1'b1;
      else if (off >= OFF_W'(3) && {1'b0, off} < HPM_END)
         cnt_ok = 1'b1;
   end

   assign lo_alias = (alias_idx == AL_VAL)    || (alias_idx == AL_CFG);
   assign hi_alias = (alias_idx == AL_VAL_HI) || (alias_idx == AL_CFG_HI);

   generate
      if (XLEN == 32) begin : g_split
         assign hi_ok = hi_alias;
      end else begin : g_whole
         assign hi_ok = 1'b0;
      end
   endgenerate

   assign tgt.hi  = hi_alias;
   assign tgt.cfg = (alias_idx == AL_CFG) || (alias_idx == AL_CFG_HI);
   assign tgt.num = off;
   assign present = in_win && cnt_ok && (lo_alias || hi_ok);
endmodule

// File: rtl/cdi_perm.sv
module cdi_perm
   import cdi_pkg::*;
(
   input  logic             in_win,
   input  logic             present,
   input  logic [OFF_W-1:0] off,
   input  logic             vs_alias,
   input  logic [1:0]       priv,
   input  logic             virt,
   input  logic             deleg_en,
   input  logic [WIN_SIZE-1:0] cnt_en,
   output logic             trap_ill,
   output logic             trap_virt
);
   logic vs_mode;
   logic low_priv;
   logic en_bit;

   assign vs_mode  = virt && (priv == PRV_S);
   assign low_priv = (priv != PRV_S) && (priv != PRV_M);
   assign en_bit   = cnt_en[off];

   always_comb begin
      trap_ill  = 1'b0;
      trap_virt = 1'b0;
      if (in_win) begin
         if (vs_mode) begin
            trap_virt = deleg_en;
            trap_ill  = !deleg_en;
         end else if (low_priv) begin
            trap_ill = 1'b1;
         end else if (!present || !deleg_en || !en_bit) begin
            trap_ill = 1'b1;
         end else if (vs_alias) begin
            trap_ill = 1'b1;
         end
      end
   end
endmodule

// File: rtl/cdi_merge.sv
module cdi_merge #(
   parameter int XLEN    = 64,
   parameter int INH_POS = 62
) (
   input  logic            cfg,
   input  logic            hi,
   input  logic [XLEN-1:0] mrd,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] wr_data,
   output logic [XLEN-1:0] rd_data
);
   localparam int          HI_SH = (INH_POS >= 32) ? INH_POS - 32 : 0;
   localparam logic [63:0] LO64  = (INH_POS < XLEN) ? (64'd1 << INH_POS) : 64'd0;
   localparam logic [63:0] HI64  = (INH_POS >= 32) ? (64'd1 << HI_SH) : 64'd0;

   logic [XLEN-1:0] inh;

   generate
      if (XLEN == 32) begin : g_split
         always_comb begin
            inh = '0;
            if (cfg) inh = hi ? HI64[XLEN-1:0] : LO64[XLEN-1:0];
         end
      end else begin : g_whole
         logic unused_hi;
         assign unused_hi = hi;
         always_comb begin
            inh = '0;
            if (cfg) inh = LO64[XLEN-1:0];
         end
      end
   endgenerate

   assign wr_data = (mrd & inh) | (wdata & ~inh);
   assign rd_data = mrd & ~inh;
endmodule

// File: rtl/cnt_deleg_ind.sv
module cnt_deleg_ind
   import cdi_pkg::*;
#(
   parameter int          XLEN     = 64,
   parameter int          SEL_W    = 12,
   parameter int unsigned WIN_BASE = 'h40,
   parameter int          NUM_HPM  = 29,
   parameter int          INH_POS  = 62
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic             acc_write,
   input  logic [SEL_W-1:0] sel,
   input  logic [2:0]       alias_idx,
   input  logic             vs_alias,
   input  logic [1:0]       priv,
   input  logic             virt,
   input  logic             deleg_en,
   input  logic [31:0]      cnt_en,
   input  logic [XLEN-1:0]  wdata,
   input  logic [XLEN-1:0]  mrd_data,
   output logic [6:0]       tgt_idx,
   output logic             mwr_en,
   output logic [XLEN-1:0]  mwr_data,
   output logic             rsp_valid,
   output logic [XLEN-1:0]  rsp_rdata,
   output logic             rsp_illegal,
   output logic             rsp_virtual,
   output logic             rsp_not_mine
);
   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("cnt_deleg_ind: XLEN must be 32 or 64");
      end
      if (NUM_HPM < 0 || NUM_HPM > 29) begin : g_bad_hpm
         $error("cnt_deleg_ind: NUM_HPM must lie in 0..29");
      end
      if (SEL_W < OFF_W + 1) begin : g_bad_sel
         $error("cnt_deleg_ind: SEL_W too narrow for the window");
      end
      if (INH_POS < 0 || INH_POS > 63) begin : g_bad_inh
         $error("cnt_deleg_ind: INH_POS must lie in 0..63");
      end
   endgenerate

   localparam logic [63:0] LO_M64 = (INH_POS < XLEN) ? (64'd1 << INH_POS) : 64'd0;
   localparam logic [XLEN-1:0] LO_M = LO_M64[XLEN-1:0];

   logic             in_win;
   logic [OFF_W-1:0] off;
   cdi_tgt_t         tgt;
   logic             present;
   logic             trap_ill;
   logic             trap_virt;
   logic             ok;
   logic [XLEN-1:0]  rd_masked;

   cdi_decode #(
      .SEL_W(SEL_W), .WIN_BASE(WIN_BASE), .NUM_HPM(NUM_HPM), .XLEN(XLEN)
   ) u_decode (
      .sel(sel), .alias_idx(alias_idx), .in_win(in_win), .off(off),
      .tgt(tgt), .present(present)
   );

   cdi_perm u_perm (
      .in_win(in_win), .present(present), .off(off), .vs_alias(vs_alias),
      .priv(priv), .virt(virt), .deleg_en(deleg_en), .cnt_en(cnt_en),
      .trap_ill(trap_ill), .trap_virt(trap_virt)
   );

   cdi_merge #(.XLEN(XLEN), .INH_POS(INH_POS)) u_merge (
      .cfg(tgt.cfg), .hi(tgt.hi), .mrd(mrd_data), .wdata(wdata),
      .wr_data(mwr_data), .rd_data(rd_masked)
   );

   assign ok      = acc_valid && in_win && !trap_ill && !trap_virt;
   assign mwr_en  = ok && acc_write;
   assign tgt_idx = tgt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_rdata    <= '0;
         rsp_illegal  <= 1'b0;
         rsp_virtual  <= 1'b0;
         rsp_not_mine <= 1'b0;
      end else begin
         rsp_valid    <= acc_valid;
         rsp_rdata    <= ok ? rd_masked : '0;
         rsp_illegal  <= acc_valid && trap_ill;
         rsp_virtual  <= acc_valid && trap_virt;
         rsp_not_mine <= acc_valid && !in_win;
      end
   end

   a_r1_unclaimed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_not_mine |-> (!rsp_illegal && !rsp_virtual && rsp_rdata == '0));

   a_r4_inh_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && tgt.cfg && !tgt.hi) |=> ((rsp_rdata & LO_M) == '0));

   a_r5_inh_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (mwr_en && tgt.cfg && !tgt.hi) |-> (((mwr_data ^ mrd_data) & LO_M) == '0));

   a_r6_no_deleg_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !deleg_en |-> !mwr_en);

   a_r8_vs_split: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && in_win && virt && priv == PRV_S) |=>
         (rsp_valid && rsp_virtual == $past(deleg_en) && rsp_illegal == !$past(deleg_en)));

   a_r10_one_trap: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_illegal && rsp_virtual));

   a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rsp_valid);

   a_r11_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !rsp_valid);
endmodule

// File: tb/cnt_deleg_ind_bench.sv
module cnt_deleg_ind_bench;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n;
   logic        acc_valid, acc_write, vs_alias, virt, deleg_en;
   logic [11:0] sel;
   logic [2:0]  alias_idx;
   logic [1:0]  priv;
   logic [31:0] cnt_en;
   logic [63:0] wdata;

   logic [6:0]  tgt_w, tgt_n;
   logic        we_w, we_n;
   logic [63:0] wd_w, rd_w, mrd_w, mrd_n64;
   logic [31:0] wd_n, rd_n;
   logic        v_w, ill_w, vir_w, nm_w, v_n, ill_n, vir_n, nm_n;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 0;

   function automatic logic [63:0] stor(input logic [6:0] idx);
      logic [7:0] b;
      b = {1'b0, idx} | 8'h40;
      return {8{b}};
   endfunction

   assign mrd_w   = stor(tgt_w);
   assign mrd_n64 = stor(tgt_n);

   cnt_deleg_ind u_cnt_deleg_ind (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .sel(sel), .alias_idx(alias_idx), .vs_alias(vs_alias), .priv(priv),
      .virt(virt), .deleg_en(deleg_en), .cnt_en(cnt_en), .wdata(wdata),
      .mrd_data(mrd_w), .tgt_idx(tgt_w), .mwr_en(we_w), .mwr_data(wd_w),
      .rsp_valid(v_w), .rsp_rdata(rd_w), .rsp_illegal(ill_w),
      .rsp_virtual(vir_w), .rsp_not_mine(nm_w)
   );

   cnt_deleg_ind #(.XLEN(32), .NUM_HPM(4)) u_cnt_deleg_ind_narrow (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .sel(sel), .alias_idx(alias_idx), .vs_alias(vs_alias), .priv(priv),
      .virt(virt), .deleg_en(deleg_en), .cnt_en(cnt_en), .wdata(wdata[31:0]),
      .mrd_data(mrd_n64[31:0]), .tgt_idx(tgt_n), .mwr_en(we_n), .mwr_data(wd_n),
      .rsp_valid(v_n), .rsp_rdata(rd_n), .rsp_illegal(ill_n),
      .rsp_virtual(vir_n), .rsp_not_mine(nm_n)
   );

   task automatic chk(input string tag, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic model(input int xl, input int nh,
                        output logic nm, output logic ill, output logic vir,
                        output logic we, output logic okd, output logic [6:0] tg,
                        output logic [63:0] wdo, output logic [63:0] rdo);
      logic inw, pres, cfg, hi;
      logic [63:0] wm, msk, mrd;
      int off;
      inw  = (sel >= 12'h40) && (sel < 12'h60);
      off  = int'(sel[4:0]);
      cfg  = (alias_idx == 3'd2) || (alias_idx == 3'd5);
      hi   = (alias_idx == 3'd4) || (alias_idx == 3'd5);
      pres = inw && (off == 0 || off == 2 || (off >= 3 && off < 3 + nh)) &&
             (alias_idx == 3'd1 || alias_idx == 3'd2 || (hi && xl == 32));
      tg   = {hi, cfg, sel[4:0]};
      wm   = (xl == 32) ? 64'hFFFF_FFFF : '1;
      msk  = !cfg ? 64'd0 : (xl == 32 ? (hi ? 64'h4000_0000 : 64'd0)
                                      : 64'h4000_0000_0000_0000);
      mrd  = stor(tg) & wm;
      ill  = 1'b0;
      vir  = 1'b0;
      if (inw) begin
         if (virt && priv == 2'd1) begin
            vir = deleg_en;
            ill = !deleg_en;
         end else if (priv != 2'd3 && priv != 2'd1) ill = 1'b1;
         else if (!pres || !deleg_en || !cnt_en[off]) ill = 1'b1;
         else if (vs_alias) ill = 1'b1;
      end
      nm  = acc_valid && !inw;
      ill = acc_valid && ill;
      vir = acc_valid && vir;
      okd = acc_valid && inw && !ill && !vir;
      we  = okd && acc_write;
      wdo = ((mrd & msk) | (wdata & ~msk)) & wm;
      rdo = okd ? (mrd & ~msk) : 64'd0;
   endtask

   task automatic step(input string tag);
      logic nm1, il1, vi1, we1, ok1, nm2, il2, vi2, we2, ok2;
      logic [6:0] tg1, tg2;
      logic [63:0] wd1, rd1, wd2, rd2;
      model(64, 29, nm1, il1, vi1, we1, ok1, tg1, wd1, rd1);
      model(32, 4,  nm2, il2, vi2, we2, ok2, tg2, wd2, rd2);
      #1;
      chk(tag, "wide mwr_en", 64'(we_w), 64'(we1));
      chk(tag, "narrow mwr_en", 64'(we_n), 64'(we2));
      if (ok1) chk(tag, "wide tgt_idx", 64'(tgt_w), 64'(tg1));
      if (ok2) chk(tag, "narrow tgt_idx", 64'(tgt_n), 64'(tg2));
      if (we1) chk(tag, "wide mwr_data", wd_w, wd1);
      if (we2) chk(tag, "narrow mwr_data", 64'(wd_n), wd2);
      @(posedge clk);
      @(negedge clk);
      chk(tag, "wide rsp_valid", 64'(v_w), 64'(acc_valid));
      chk(tag, "narrow rsp_valid", 64'(v_n), 64'(acc_valid));
      chk(tag, "wide not_mine", 64'(nm_w), 64'(nm1));
      chk(tag, "narrow not_mine", 64'(nm_n), 64'(nm2));
      chk(tag, "wide illegal", 64'(ill_w), 64'(il1));
      chk(tag, "narrow illegal", 64'(ill_n), 64'(il2));
      chk(tag, "wide virtual", 64'(vir_w), 64'(vi1));
      chk(tag, "narrow virtual", 64'(vir_n), 64'(vi2));
      chk(tag, "wide rdata", rd_w, rd1);
      chk(tag, "narrow rdata", 64'(rd_n), rd2);
   endtask

   task automatic acc(input string tag, input logic [11:0] s, input logic [2:0] al,
                      input logic va, input logic [1:0] pv, input logic vt,
                      input logic dg, input logic [31:0] ce, input logic w,
                      input logic [63:0] wd);
      acc_valid = 1'b1; sel = s; alias_idx = al; vs_alias = va; priv = pv;
      virt = vt; deleg_en = dg; cnt_en = ce; acc_write = w; wdata = wd;
      step(tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; sel = '0; alias_idx = '0;
      vs_alias = 1'b0; priv = 2'd3; virt = 1'b0; deleg_en = 1'b0; cnt_en = '0;
      wdata = '0;
      repeat (3) @(negedge clk);
      chk("R11", "reset rsp_valid", 64'(v_w | v_n), 64'd0);
      chk("R11", "reset traps", 64'(ill_w | vir_w | ill_n | vir_n | nm_w | nm_n), 64'd0);
      chk("R11", "reset rdata", rd_w | 64'(rd_n), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      acc("R1", 12'h03F, 3'd1, 0, 2'd3, 0, 1, '1, 0, 0);
      acc("R1", 12'h060, 3'd1, 0, 2'd3, 0, 1, '1, 1, '1);
      acc("R2", 12'h040, 3'd1, 0, 2'd3, 0, 1, '1, 0, 0);
      acc("R2", 12'h042, 3'd1, 0, 2'd3, 0, 1, '1, 0, 0);
      acc("R2", 12'h041, 3'd1, 0, 2'd3, 0, 1, '1, 0, 0);
      acc("R2", 12'h046, 3'd1, 0, 2'd3, 0, 1, '1, 0, 0);
      acc("R2", 12'h047, 3'd1, 0, 2'd3, 0, 1, '1, 0, 0);
      acc("R2", 12'h05F, 3'd1, 0, 2'd3, 0, 1, '1, 0, 0);
      acc("R3", 12'h043, 3'd3, 0, 2'd3, 0, 1, '1, 0, 0);
      acc("R3", 12'h043, 3'd6, 0, 2'd3, 0, 1, '1, 0, 0);
      acc("R3", 12'h043, 3'd4, 0, 2'd3, 0, 1, '1, 0, 0);
      acc("R3", 12'h043, 3'd0, 0, 2'd3, 0, 1, '1, 0, 0);
      acc("R4", 12'h043, 3'd2, 0, 2'd3, 0, 1, '1, 0, 0);
      acc("R4", 12'h044, 3'd5, 0, 2'd1, 0, 1, '1, 0, 0);
      acc("R5", 12'h040, 3'd2, 0, 2'd3, 0, 1, '1, 1, 64'd0);
      acc("R5", 12'h045, 3'd2, 0, 2'd3, 0, 1, '1, 1, '1);
      acc("R5", 12'h042, 3'd5, 0, 2'd3, 0, 1, '1, 1, 64'h1234_5678_0000_0000);
      acc("R5", 12'h042, 3'd1, 0, 2'd3, 0, 1, '1, 1, 64'hDEAD_BEEF_CAFE_F00D);
      acc("R6", 12'h043, 3'd1, 0, 2'd3, 0, 0, '1, 1, '1);
      acc("R6", 12'h043, 3'd1, 0, 2'd1, 0, 1, 32'hFFFF_FFF7, 1, '1);
      acc("R6", 12'h043, 3'd1, 0, 2'd1, 0, 1, 32'h0000_0008, 0, 0);
      acc("R7", 12'h040, 3'd1, 1, 2'd3, 0, 1, '1, 1, '1);
      acc("R7", 12'h042, 3'd2, 1, 2'd1, 0, 1, '1, 0, 0);
      acc("R8", 12'h040, 3'd1, 0, 2'd1, 1, 1, '1, 1, '1);
      acc("R8", 12'h040, 3'd1, 0, 2'd1, 1, 0, '1, 0, 0);
      acc("R8", 12'h041, 3'd3, 1, 2'd1, 1, 1, '1, 0, 0);
      acc("R9", 12'h040, 3'd1, 0, 2'd0, 0, 1, '1, 1, '1);
      acc("R9", 12'h040, 3'd1, 0, 2'd2, 0, 1, '1, 0, 0);
      acc("R9", 12'h040, 3'd1, 0, 2'd0, 1, 1, '1, 0, 0);
      acc("R10", 12'h041, 3'd2, 0, 2'd3, 0, 1, '1, 1, '1);
      acc_valid = 1'b0;
      step("R11");

      for (int i = 0; i < 800; i++) begin
         logic [1:0] pv;
         case ($urandom % 6)
            0, 1: pv = 2'd3;
            2, 3: pv = 2'd1;
            4:    pv = 2'd0;
            default: pv = 2'd2;
         endcase
         acc_valid = ($urandom % 8) != 0;
         acc("R6", 12'h038 + 12'($urandom % 48), 3'($urandom % 8),
             ($urandom % 6) == 0, pv, ($urandom % 4) == 0, ($urandom % 5) != 0,
             (($urandom % 4) != 0) ? 32'hFFFF_FFFF : 32'($urandom),
             1'($urandom % 2), {32'($urandom), 32'($urandom)});
         if (($urandom % 8) == 0) begin
            acc_valid = 1'b0;
            step("R11");
         end
      end
      finish_run();
   end
endmodule